// File: doc/BRIEF.md
# Timing Source Selection Controller

This controller chooses the timing reference that drives a radio unit's timebase and tracks how well that reference is disciplined. Three external references compete for selection: a packet-based time source, a physical-layer frequency source and a pulse-per-second input that carries time of day. A local free-running oscillator is the fallback. Each external source supplies a valid flag and a quality flag. The block takes the highest-priority source that has stayed usable for a programmable qualification time. When the selected reference is lost, it falls back in a defined way and raises an alarm.

While an external source is selected, a signed time-error figure arrives with a strobe. Its magnitude is compared against two programmed limits and grades the lock as locked, degraded or out of spec. While the local oscillator carries the unit, the state is holdover and a counter measures how long that has lasted. Every change of selected source increments a switch counter and places an event in a small FIFO. The event holds the cycle timestamp, a 3-bit reason code and the new source. A force input lets an operator pin the selection.

Top module: `tsc_timing_select`

## Requirements
- R1: After reset the selection is the local source (code 3), the lock state is holdover (code 1), the alarm is high, and the holdover count, switch count and event FIFO are all empty or zero.
- R2: The source codes on `selSrc` are: 0 packet, 1 physical frequency, 2 pulse-per-second, 3 local. Among qualified sources, the lower code always wins.
- R3: An external source is usable while its valid and quality bits are both high. It becomes qualified only at the edge where it has been usable for `qualTime`+1 consecutive sampled edges. Any non-usable edge restarts the count.
- R4: If the selected external source stops being usable, the block switches at that edge to the best qualified source, or to local if none is qualified. The reason is 1 if valid was low, and 2 if valid was high but quality was low.
- R5: Lock state codes are 0 locked, 1 holdover, 2 degraded, 3 out of spec. The state is holdover whenever the local source is selected or the selected source is not usable. Otherwise the state is taken from the latched magnitude of the time error: 3 if it is at or above `oosThresh`, 2 if it is at or above `degThresh`, and 0 if it is below both. The magnitude is latched on `teStrobe`, is cleared to zero by a switch, and shows in the state one cycle after the edge where it was latched.
- R6: `alarm` is high exactly when the lock state is not locked.
- R7: `holdCount` is 0 outside holdover and on the edge that enters holdover. It then rises by one per cycle in holdover and saturates at its maximum value.
- R8: When a qualified source with a lower code than the selected one is available, the block switches to it with reason 3.
- R9: While `forceEn` is high, the selection follows `forceSrc` with reason 4, and no automatic switch takes place.
- R10: Each switch increments `switchCount`, which wraps. Each switch also pushes an event: `evData` holds the timestamp in bits [TS_W+4:5], the reason in [4:2] and the new source in [1:0]. The timestamp is the number of clock edges since reset, taken at the switching edge.
- R11: The FIFO returns events oldest first, and `evPop` removes the head. A push into a full FIFO is discarded unless a pop happens on the same edge; the switch count still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extValid | input | 3 | Per external source presence flag, bit index = source code |
| extGood | input | 3 | Per external source quality flag |
| teSample | input | TE_W | Signed time-error sample |
| teStrobe | input | 1 | Latch `teSample` this cycle |
| degThresh | input | TE_W | Degraded limit on time-error magnitude |
| oosThresh | input | TE_W | Out-of-spec limit on time-error magnitude |
| qualTime | input | QUAL_W | Qualification time in cycles |
| forceEn | input | 1 | Manual selection enable |
| forceSrc | input | 2 | Source code to force |
| evPop | input | 1 | Remove head event |
| selSrc | output | 2 | Selected source code |
| lockState | output | 2 | Lock state code |
| alarm | output | 1 | Lock not healthy |
| holdCount | output | HOLD_W | Cycles spent in holdover |
| switchCount | output | CNT_W | Number of switches, wrapping |
| evValid | output | 1 | FIFO holds at least one event |
| evData | output | TS_W+5 | Head event |

## Verification
The bench builds the block with a 4-bit qualification field driven to 3, a 6-bit holdover counter, a 4-bit switch counter, a 12-bit timestamp, a 16-bit time error and a four-entry FIFO. With these values, holdover saturation at 63 can be reached within a directed stretch, and the switch counter wraps during the random phase. Six forced switches in a row overflow the FIFO. The most negative 16-bit sample tests the magnitude edge case.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int NUM_EXT = 3;

  typedef enum logic [1:0] {
    SRC_PKT   = 2'd0,
    SRC_PHY   = 2'd1,
    SRC_PPS   = 2'd2,
    SRC_LOCAL = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_LOCKED   = 2'd0,
    ST_HOLDOVER = 2'd1,
    ST_DEGRADED = 2'd2,
    ST_OOS      = 2'd3
  } lock_e;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_LOS   = 3'd1,
    RSN_QUAL  = 3'd2,
    RSN_PRIO  = 3'd3,
    RSN_FORCE = 3'd4
  } reason_e;

  typedef struct packed {
    logic    doSwitch;
    reason_e reason;
    src_e    newSrc;
    logic    holdRun;
  } ctl_strobe_t;
endpackage

// File: rtl/tsc_select_ctrl.sv
module tsc_select_ctrl
  import tsc_pkg::*;
#(
  parameter int TE_W   = 24,
  parameter int QUAL_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extValid,
  input  logic [NUM_EXT-1:0]  extGood,
  input  logic [QUAL_W-1:0]   qualTime,
  input  logic                forceEn,
  input  logic [1:0]          forceSrc,
  input  logic [TE_W-1:0]     teMag,
  input  logic [TE_W-1:0]     degThresh,
  input  logic [TE_W-1:0]     oosThresh,
  output src_e                selSrc,
  output lock_e               lockState,
  output logic                alarm,
  output ctl_strobe_t         strobe
);
  logic [NUM_EXT-1:0] usable;
  logic [NUM_EXT-1:0] qualified;
  logic [3:0]         usable4;
  logic [3:0]         valid4;
  logic [3:0]         qual4;
  src_e               best;
  src_e               nextSel;
  lock_e              nextState;
  logic               doSw;
  reason_e            rsn;

  assign usable  = extValid & extGood;
  assign usable4 = {{(4-NUM_EXT){1'b0}}, usable};
  assign valid4  = {{(4-NUM_EXT){1'b0}}, extValid};
  assign qual4   = {{(4-NUM_EXT){1'b0}}, qualified};

  // per-source qualification timers
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_qual
    logic [QUAL_W-1:0] upCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                upCnt <= '0;
      else if (!usable[i])      upCnt <= '0;
      else if (upCnt < qualTime) upCnt <= upCnt + 1'b1;
    end
    assign qualified[i] = usable[i] && (upCnt >= qualTime);
  end

  // fixed priority: lowest code first
  always_comb begin
    best = SRC_LOCAL;
    for (int i = NUM_EXT - 1; i >= 0; i--) begin
      if (qualified[i]) best = src_e'(2'(i));
    end
  end

  always_comb begin
    doSw    = 1'b0;
    rsn     = RSN_NONE;
    nextSel = selSrc;
    if (forceEn) begin
      if (src_e'(forceSrc) != selSrc) begin
        doSw    = 1'b1;
        rsn     = RSN_FORCE;
        nextSel = src_e'(forceSrc);
      end
    end else if (selSrc != SRC_LOCAL && !usable4[selSrc]) begin
      doSw    = 1'b1;
      rsn     = valid4[selSrc] ? RSN_QUAL : RSN_LOS;
      nextSel = best;
    end else if (best < selSrc) begin
      doSw    = 1'b1;
      rsn     = RSN_PRIO;
      nextSel = best;
    end
  end

  always_comb begin
    if (nextSel == SRC_LOCAL || !usable4[nextSel]) nextState = ST_HOLDOVER;
    else if (doSw)                                 nextState = ST_LOCKED;
    else if (teMag >= oosThresh)                   nextState = ST_OOS;
    else if (teMag >= degThresh)                   nextState = ST_DEGRADED;
    else                                           nextState = ST_LOCKED;
  end

  assign strobe.doSwitch = doSw;
  assign strobe.reason   = rsn;
  assign strobe.newSrc   = nextSel;
  assign strobe.holdRun  = (nextState == ST_HOLDOVER) && (lockState == ST_HOLDOVER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSrc    <= SRC_LOCAL;
      lockState <= ST_HOLDOVER;
      alarm     <= 1'b1;
    end else begin
      selSrc    <= nextSel;
      lockState <= nextState;
      alarm     <= (nextState != ST_LOCKED);
    end
  end

  // R5: local selection always means holdover
  assert_hold_on_local_R5: assert property (@(posedge clk) disable iff (!rstN)
    (selSrc == SRC_LOCAL) |-> (lockState == ST_HOLDOVER));

  // R3: a priority switch only targets a qualified source
  assert_prio_qualified_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doSw && rsn == RSN_PRIO) |-> qual4[nextSel]);

  // R9: forced selection is never overridden
  assert_force_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    forceEn |=> (selSrc == src_e'($past(forceSrc))));
endmodule

// File: rtl/tsc_event_path.sv
module tsc_event_path
  import tsc_pkg::*;
#(
  parameter int TE_W       = 24,
  parameter int HOLD_W     = 32,
  parameter int CNT_W      = 16,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 8,
  localparam int EV_W      = TS_W + 5,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_strobe_t            strobe,
  input  logic signed [TE_W-1:0] teSample,
  input  logic                   teStrobe,
  input  logic                   evPop,
  output logic [TE_W-1:0]        teMag,
  output logic [HOLD_W-1:0]      holdCount,
  output logic [CNT_W-1:0]       switchCount,
  output logic                   evValid,
  output logic [EV_W-1:0]        evData
);
  localparam logic [PTR_W:0]   FULL_C = (PTR_W + 1)'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_C = PTR_W'(FIFO_DEPTH - 1);

  logic [TE_W-1:0]  absVal;
  logic [TS_W-1:0]  tsCnt;
  logic [EV_W-1:0]  mem [FIFO_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [PTR_W:0]   fillCnt;
  logic             doPop, doPush;

  assign absVal = teSample[TE_W-1] ? TE_W'(-teSample) : TE_W'(teSample);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      teMag       <= '0;
      holdCount   <= '0;
      tsCnt       <= '0;
      switchCount <= '0;
    end else begin
      tsCnt <= tsCnt + 1'b1;
      if (strobe.doSwitch) teMag <= '0;
      else if (teStrobe)   teMag <= absVal;
      if (!strobe.holdRun)  holdCount <= '0;
      else if (!(&holdCount)) holdCount <= holdCount + 1'b1;
      if (strobe.doSwitch) switchCount <= switchCount + 1'b1;
    end
  end

  assign doPop  = evPop && (fillCnt != '0);
  assign doPush = strobe.doSwitch && ((fillCnt < FULL_C) || doPop);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {tsCnt, strobe.reason, strobe.newSrc};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (doPop)  rdPtr <= (rdPtr == LAST_C) ? '0 : rdPtr + 1'b1;
      if (doPush) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + 1'b1;
      if (doPush && !doPop)      fillCnt <= fillCnt + 1'b1;
      else if (doPop && !doPush) fillCnt <= fillCnt - 1'b1;
    end
  end

  assign evValid = (fillCnt != '0);
  assign evData  = mem[rdPtr];

  // R10: counter advances by one per switch and holds otherwise
  assert_switch_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doSwitch |=> (switchCount == $past(switchCount) + 1'b1));
  assert_switch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doSwitch |=> $stable(switchCount));

  // R11: occupancy never exceeds depth
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FULL_C);
endmodule

// File: rtl/tsc_timing_select.sv
module tsc_timing_select
  import tsc_pkg::*;
#(
  parameter int TE_W       = 24,
  parameter int QUAL_W     = 16,
  parameter int HOLD_W     = 32,
  parameter int CNT_W      = 16,
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 8,
  localparam int EV_W      = TS_W + 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2:0]             extValid,
  input  logic [2:0]             extGood,
  input  logic signed [TE_W-1:0] teSample,
  input  logic                   teStrobe,
  input  logic [TE_W-1:0]        degThresh,
  input  logic [TE_W-1:0]        oosThresh,
  input  logic [QUAL_W-1:0]      qualTime,
  input  logic                   forceEn,
  input  logic [1:0]             forceSrc,
  input  logic                   evPop,
  output logic [1:0]             selSrc,
  output logic [1:0]             lockState,
  output logic                   alarm,
  output logic [HOLD_W-1:0]      holdCount,
  output logic [CNT_W-1:0]       switchCount,
  output logic                   evValid,
  output logic [EV_W-1:0]        evData
);
  ctl_strobe_t     strobe;
  logic [TE_W-1:0] teMag;
  src_e            selE;
  lock_e           lockE;

  tsc_select_ctrl #(.TE_W(TE_W), .QUAL_W(QUAL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .extValid(extValid), .extGood(extGood),
    .qualTime(qualTime), .forceEn(forceEn), .forceSrc(forceSrc),
    .teMag(teMag), .degThresh(degThresh), .oosThresh(oosThresh),
    .selSrc(selE), .lockState(lockE), .alarm(alarm), .strobe(strobe)
  );

  tsc_event_path #(
    .TE_W(TE_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W), .TS_W(TS_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .teSample(teSample),
    .teStrobe(teStrobe), .evPop(evPop), .teMag(teMag), .holdCount(holdCount),
    .switchCount(switchCount), .evValid(evValid), .evData(evData)
  );

  assign selSrc    = selE;
  assign lockState = lockE;

  // R6: alarm register agrees with the state register
  assert_alarm_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    alarm == (lockState != 2'd0));

  // R7: holdover timer is idle outside holdover
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockState != 2'd1) |-> (holdCount == '0));
endmodule

// File: tb/tsc_timing_select_bench.sv
`timescale 1ns/1ps
module tsc_timing_select_bench;
  localparam int TE_W = 16, QUAL_W = 4, HOLD_W = 6, CNT_W = 4, TS_W = 12, DEPTH = 4;
  localparam int EV_W = TS_W + 5;
  localparam int HOLD_MAX = (1 << HOLD_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] vIn = '0, gIn = '0;
  logic signed [TE_W-1:0] teIn = '0;
  logic stbIn = 1'b0, popIn = 1'b0, forceIn = 1'b0;
  logic [1:0] fsrcIn = '0;
  logic [TE_W-1:0] degT = 16'd100, oosT = 16'd1000;
  logic [QUAL_W-1:0] qualT = 4'd3;

  logic [1:0] selSrc, lockState;
  logic alarm, evValid;
  logic [HOLD_W-1:0] holdCount;
  logic [CNT_W-1:0] switchCount;
  logic [EV_W-1:0] evData;

  always #10 clk = ~clk;

  tsc_timing_select #(
    .TE_W(TE_W), .QUAL_W(QUAL_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W),
    .TS_W(TS_W), .FIFO_DEPTH(DEPTH)
  ) u_tsc_timing_select (
    .clk(clk), .rstN(rstN), .extValid(vIn), .extGood(gIn), .teSample(teIn),
    .teStrobe(stbIn), .degThresh(degT), .oosThresh(oosT), .qualTime(qualT),
    .forceEn(forceIn), .forceSrc(fsrcIn), .evPop(popIn), .selSrc(selSrc),
    .lockState(lockState), .alarm(alarm), .holdCount(holdCount),
    .switchCount(switchCount), .evValid(evValid), .evData(evData)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // reference model state
  int mSel, mState, mHold, mSw, mTs, mTe, mCnt;
  int mQ[3];
  int mFifo[DEPTH];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int magOf(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int evWord(int ts, int rsn, int src);
    return (ts << 5) | (rsn << 2) | src;
  endfunction

  task automatic modelReset();
    mSel = 3; mState = 1; mHold = 0; mSw = 0; mTs = 0; mTe = 0; mCnt = 0;
    for (int i = 0; i < 3; i++) mQ[i] = 0;
    for (int i = 0; i < DEPTH; i++) mFifo[i] = 0;
  endtask

  task automatic modelStep();
    bit [3:0] u;
    bit [3:0] vv;
    bit q[3];
    int best, nSel, nState, rsn;
    bit sw, pop, push;
    u  = {1'b0, vIn & gIn};
    vv = {1'b0, vIn};
    for (int i = 0; i < 3; i++) q[i] = u[i] && (mQ[i] >= int'(qualT));
    best = 3;
    for (int i = 2; i >= 0; i--) if (q[i]) best = i;
    sw = 0; rsn = 0; nSel = mSel;
    if (forceIn) begin
      if (int'(fsrcIn) != mSel) begin sw = 1; rsn = 4; nSel = int'(fsrcIn); end
    end else if (mSel != 3 && !u[mSel]) begin
      sw = 1; rsn = vv[mSel] ? 2 : 1; nSel = best;
    end else if (best < mSel) begin
      sw = 1; rsn = 3; nSel = best;
    end
    if (nSel == 3 || !u[nSel])     nState = 1;
    else if (sw)                   nState = 0;
    else if (mTe >= int'(oosT))    nState = 3;
    else if (mTe >= int'(degT))    nState = 2;
    else                           nState = 0;
    mHold = (nState == 1 && mState == 1) ? ((mHold < HOLD_MAX) ? mHold + 1 : mHold) : 0;
    for (int i = 0; i < 3; i++) begin
      if (!u[i]) mQ[i] = 0;
      else if (mQ[i] < int'(qualT)) mQ[i]++;
    end
    if (sw) mTe = 0;
    else if (stbIn) mTe = magOf(int'(teIn));
    pop  = popIn && (mCnt > 0);
    push = sw && ((mCnt < DEPTH) || pop);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mFifo[i] = mFifo[i+1];
      mCnt--;
    end
    if (push) begin mFifo[mCnt] = evWord(mTs, rsn, nSel); mCnt++; end
    if (sw) mSw = (mSw + 1) % (1 << CNT_W);
    mTs = (mTs + 1) % (1 << TS_W);
    mSel = nSel; mState = nState;
  endtask

  task automatic compareAll();
    chk(int'(selSrc) == mSel, "R2 selected source", selSrc, mSel);
    chk(int'(lockState) == mState, "R5 lock state", lockState, mState);
    chk(alarm == (mState != 0), "R6 alarm", alarm, (mState != 0));
    chk(int'(holdCount) == mHold, "R7 holdover count", holdCount, mHold);
    chk(int'(switchCount) == mSw, "R10 switch count", switchCount, mSw);
    chk(evValid == (mCnt > 0), "R11 event valid", evValid, (mCnt > 0));
    if (mCnt > 0) chk(int'(evData) == mFifo[0], "R10 event word", evData, mFifo[0]);
  endtask

  task automatic cyc(logic [2:0] v, logic [2:0] g, logic stb, int te, logic pop,
                     logic fen, logic [1:0] fs);
    vIn = v; gIn = g; stbIn = stb; teIn = TE_W'(te); popIn = pop;
    forceIn = fen; fsrcIn = fs;
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(logic [2:0] v, logic [2:0] g);
    cyc(v, g, 1'b0, 0, 1'b0, 1'b0, 2'd0);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int swBase;
    void'($urandom(32'd4321));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(selSrc == 2'd3, "R1 reset source", selSrc, 3);
    chk(lockState == 2'd1, "R1 reset state", lockState, 1);
    chk(alarm == 1'b1, "R1 reset alarm", alarm, 1);
    chk(holdCount == '0 && switchCount == '0, "R1 reset counters", holdCount + switchCount, 0);
    chk(evValid == 1'b0, "R1 reset fifo", evValid, 0);

    // R3: packet source needs qualTime+1 usable edges
    repeat (3) idle(3'b001, 3'b001);
    chk(selSrc == 2'd3, "R3 not yet qualified", selSrc, 3);
    idle(3'b001, 3'b001);
    chk(selSrc == 2'd0, "R8 relock to packet", selSrc, 0);
    chk(evData[4:2] == 3'd3 && evData[1:0] == 2'd0, "R8 reason higher priority", evData[4:0], 5'b01100);
    chk(lockState == 2'd0, "R5 locked after relock", lockState, 0);

    // R5 time error grading and its one-cycle latency
    cyc(3'b001, 3'b001, 1'b1, -150, 1'b0, 1'b0, 2'd0);
    chk(lockState == 2'd0, "R5 latch latency", lockState, 0);
    idle(3'b001, 3'b001);
    chk(lockState == 2'd2, "R5 degraded", lockState, 2);
    chk(alarm == 1'b1, "R6 alarm on degraded", alarm, 1);
    cyc(3'b001, 3'b001, 1'b1, -32768, 1'b0, 1'b0, 2'd0);
    idle(3'b001, 3'b001);
    chk(lockState == 2'd3, "R5 out of spec at most negative", lockState, 3);
    cyc(3'b001, 3'b001, 1'b1, 5, 1'b0, 1'b0, 2'd0);
    idle(3'b001, 3'b001);
    chk(lockState == 2'd0 && alarm == 1'b0, "R6 alarm clears", {lockState, alarm}, 0);

    // R2: a lower-priority qualified source does not take over
    repeat (6) idle(3'b011, 3'b011);
    chk(selSrc == 2'd0, "R2 priority keeps packet", selSrc, 0);
    cyc(3'b011, 3'b011, 1'b0, 0, 1'b1, 1'b0, 2'd0);   // drop the old event

    // R4 loss of signal falls to next qualified source
    idle(3'b010, 3'b011);
    chk(selSrc == 2'd1, "R4 fallback source", selSrc, 1);
    chk(evData[4:2] == 3'd1, "R4 reason loss of signal", evData[4:2], 1);
    cyc(3'b010, 3'b011, 1'b0, 0, 1'b1, 1'b0, 2'd0);

    // R4 quality drop with nothing qualified: holdover
    idle(3'b010, 3'b001);
    chk(selSrc == 2'd3 && lockState == 2'd1, "R4 holdover entry", {selSrc, lockState}, 13);
    chk(evData[4:2] == 3'd2, "R4 reason quality drop", evData[4:2], 2);
    chk(holdCount == '0, "R7 zero on entry", holdCount, 0);
    cyc(3'b000, 3'b000, 1'b0, 0, 1'b1, 1'b0, 2'd0);
    repeat (4) idle(3'b000, 3'b000);
    chk(holdCount == 6'd5, "R7 counting", holdCount, 5);
    repeat (70) idle(3'b000, 3'b000);
    chk(int'(holdCount) == HOLD_MAX, "R7 saturation", holdCount, HOLD_MAX);

    // R9 force pins selection even to an unusable source
    cyc(3'b000, 3'b000, 1'b0, 0, 1'b0, 1'b1, 2'd2);
    chk(selSrc == 2'd2 && lockState == 2'd1, "R9 forced source", {selSrc, lockState}, 9);
    chk(evData[4:2] == 3'd4, "R9 reason manual", evData[4:2], 4);
    repeat (10) cyc(3'b001, 3'b001, 1'b0, 0, 1'b0, 1'b1, 2'd2);
    chk(selSrc == 2'd2, "R9 no auto switch under force", selSrc, 2);
    idle(3'b001, 3'b001);
    chk(selSrc == 2'd0, "R4 release force then fall back", selSrc, 0);
    for (int k = 0; k < 8; k++) cyc(3'b001, 3'b001, 1'b0, 0, 1'b1, 1'b0, 2'd0);
    chk(evValid == 1'b0, "R11 drained", evValid, 0);

    // R11 overflow: six forced switches into four slots
    swBase = int'(switchCount);
    for (int k = 1; k <= 6; k++) cyc(3'b001, 3'b001, 1'b0, 0, 1'b0, 1'b1, 2'(k % 4));
    chk(int'(switchCount) == (swBase + 6) % 16, "R10 count through overflow", switchCount, (swBase + 6) % 16);
    for (int k = 1; k <= 4; k++) begin
      chk(evValid && int'(evData[1:0]) == k % 4, "R11 oldest first", evData[1:0], k % 4);
      cyc(3'b001, 3'b001, 1'b0, 0, 1'b1, 1'b1, 2'd2);
    end
    chk(evValid == 1'b0, "R11 newer entries dropped", evValid, 0);

    // random phase
    begin
      logic [2:0] rv, rg;
      logic rf;
      logic [1:0] rs;
      rv = 3'b111; rg = 3'b111; rf = 1'b0; rs = 2'd0;
      for (int n = 0; n < 4000; n++) begin
        int te;
        int pick;
        for (int i = 0; i < 3; i++) begin
          if ($urandom_range(15) == 0) rv[i] = ~rv[i];
          if ($urandom_range(23) == 0) rg[i] = ~rg[i];
        end
        if ($urandom_range(63) == 0) begin rf = ~rf; rs = 2'($urandom_range(3)); end
        pick = $urandom_range(9);
        if (pick < 5)      te = $urandom_range(160) - 80;
        else if (pick < 8) te = $urandom_range(1800) - 900;
        else if (pick < 9) te = $urandom_range(65534) - 32767;
        else               te = -32768;
        cyc(rv, rg, 1'($urandom_range(3) == 0), te, 1'($urandom_range(2) == 0), rf, rs);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule